// File: doc/BRIEF.md
# Floating-Point Status Word Update Unit

This block holds the 32-bit status and control word that sits beside a floating-point arithmetic unit. It decodes the rounding-mode field and the flush-to-zero control, and sends them to the datapath as steady outputs. When an arithmetic operation finishes, the datapath reports five raw exception flags. The unit merges them into sticky flag bits, and it raises a one-cycle trap request if any reported flag has its enable set.

When a compare finishes, the datapath reports the relation it found, the condition mask from the instruction, and a target index. The unit takes the mask bit that the relation selects. It either writes that bit into one addressed condition bit, or pushes it into the main condition bit while the old value moves down a ten-entry history queue.

Software can load the whole word through a write port, and that write wins over any strobe in the same cycle. All updates are registered and take effect on the clock edge that samples the strobe.

Top module: `fpsw_unit`

## Requirements
- R1: While reset is asserted and just after it is released, the status word reads 0 and trap_req is low. This means nearest-even rounding with flush-to-zero off.
- R2: With wr_en high, the status word takes wr_data at the next edge. Any op_done or cmp_done in that cycle has no effect, and trap_req stays low in the following cycle.
- R3: round_mode mirrors status bits 10:9 with this code: 0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward -infinity. flush_en mirrors status bit 5.
- R4: Flags are numbered bit 0 inexact, bit 1 underflow, bit 2 overflow, bit 3 divide-by-zero, bit 4 invalid. On op_done, each set op_flags bit i sets status bit 27+i. These sticky bits are cleared only by a write.
- R5: trap_req is high in the cycle after an edge at which the strobed flags, ANDed with the enables in status bits 4:0 before the edge, give a nonzero result. Otherwise trap_req is low.
- R6: An op_done strobe with all flags zero leaves the status word unchanged.
- R7: On cmp_done, cmp_rel selects the result bit from cmp_mask: code 0 (greater) takes mask bit 4, code 1 (less) takes bit 3, code 2 (equal) takes bit 2, and code 3 (unordered) takes bit 1. Mask bit 0 does not affect the word.
- R8: A compare with cmp_target y in 1..11 writes the result into status bit 22-y. No other condition bit changes.
- R9: A compare with cmp_target 0 does three things: bits 20:11 take the old bits 21:12, bit 21 takes the old bit 26, and bit 26 takes the result.
- R10: cmp_flags are merged like op flags in the same edge as the condition update. When op_done and cmp_done coincide, both flag sets are ORed in.
- R11: A compare with cmp_target 12..15 changes no condition bit. Its flags still apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Load the whole word |
| wr_data | input | 32 | Word to load |
| op_done | input | 1 | Arithmetic operation completed |
| op_flags | input | 5 | Raw exception flags of the operation |
| cmp_done | input | 1 | Compare completed |
| cmp_rel | input | 2 | Relation found: 0 gt, 1 lt, 2 eq, 3 unordered |
| cmp_mask | input | 5 | Condition mask of the compare |
| cmp_target | input | 4 | 0 selects the queue, 1..11 a condition bit |
| cmp_flags | input | 5 | Exception flags raised by the compare |
| status | output | 32 | Current status word |
| round_mode | output | 2 | Decoded rounding mode |
| flush_en | output | 1 | Flush-to-zero enable |
| trap_req | output | 1 | One-cycle trap request |

## Verification
The assertions assume that wr_en, op_done and cmp_done are never unknown outside reset. They also assume that the flag and compare fields are valid whenever their strobe is high. The stimulus drives every input to a defined value after each falling edge. It keeps writes rare so that sticky flags and queue contents build up over many compares. Target indices cover the whole 4-bit range, including values above 11, and strobes are allowed to coincide with one another and with writes.

// File: rtl/fpsw_pkg.sv
package fpsw_pkg;
  localparam int WORD_W   = 32;
  localparam int NFLAG    = 5;
  localparam int STICKY_LO = 27;
  localparam int ENA_LO    = 0;
  localparam int RND_LO    = 9;
  localparam int FLUSH_BIT = 5;
  localparam int COND_BIT  = 26;
  localparam int QDEPTH    = 10;
  localparam int CQ_LO     = 11;
  localparam int CQ_HI     = CQ_LO + QDEPTH;
  localparam int TGT_W     = 4;

  typedef enum logic [1:0] {
    RND_NEAREST = 2'd0,
    RND_ZERO    = 2'd1,
    RND_POS     = 2'd2,
    RND_NEG     = 2'd3
  } rnd_t;

  typedef enum logic [1:0] {
    REL_GT  = 2'd0,
    REL_LT  = 2'd1,
    REL_EQ  = 2'd2,
    REL_UNO = 2'd3
  } rel_t;

  // Mask bit picked by a relation: gt->4, lt->3, eq->2, unordered->1
  function automatic logic pick_result(input logic [1:0] rel, input logic [4:0] mask);
    logic r;
    case (rel_t'(rel))
      REL_GT:  r = mask[4];
      REL_LT:  r = mask[3];
      REL_EQ:  r = mask[2];
      default: r = mask[1];
    endcase
    return r;
  endfunction

  function automatic logic [NFLAG-1:0] gather_flags(
    input logic op_v, input logic [NFLAG-1:0] op_f,
    input logic cmp_v, input logic [NFLAG-1:0] cmp_f);
    return (op_v ? op_f : '0) | (cmp_v ? cmp_f : '0);
  endfunction
endpackage

// File: rtl/fpsw_decode.sv
module fpsw_decode
  import fpsw_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output rnd_t              rnd,
  output logic              flush
);
  always_comb begin
    rnd   = rnd_t'(word[RND_LO+1:RND_LO]);
    flush = word[FLUSH_BIT];
  end
endmodule

// File: rtl/fpsw_flag_merge.sv
module fpsw_flag_merge
  import fpsw_pkg::*;
(
  input  logic [NFLAG-1:0] sticky_cur,
  input  logic [NFLAG-1:0] enables,
  input  logic             op_v,
  input  logic [NFLAG-1:0] op_f,
  input  logic             cmp_v,
  input  logic [NFLAG-1:0] cmp_f,
  output logic [NFLAG-1:0] sticky_nxt,
  output logic             trap_hit
);
  logic [NFLAG-1:0] raised;
  logic [NFLAG-1:0] hit_vec;

  always_comb raised = gather_flags(op_v, op_f, cmp_v, cmp_f);

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_comb begin
      sticky_nxt[i] = sticky_cur[i] | raised[i];
      hit_vec[i]    = raised[i] & enables[i];
    end
  end

  always_comb trap_hit = |hit_vec;
endmodule

// File: rtl/fpsw_cond_update.sv
module fpsw_cond_update
  import fpsw_pkg::*;
(
  input  logic              cmp_v,
  input  logic [1:0]        rel,
  input  logic [4:0]        mask,
  input  logic [TGT_W-1:0]  target,
  input  logic              cb_cur,
  input  logic [QDEPTH:0]   cq_cur,
  output logic              cb_nxt,
  output logic [QDEPTH:0]   cq_nxt,
  output logic              result
);
  logic queued;

  always_comb begin
    result = pick_result(rel, mask);
    queued = cmp_v && (target == '0);
    cb_nxt = queued ? result : cb_cur;
  end

  // Field index i holds status bit CQ_LO+i; target y lands on index QDEPTH+1-y
  for (genvar i = 0; i <= QDEPTH; i++) begin : g_cq
    logic tgt_hit;
    always_comb begin
      tgt_hit = cmp_v && (target == TGT_W'(QDEPTH + 1 - i));
      if (queued)
        cq_nxt[i] = (i == QDEPTH) ? cb_cur : cq_cur[(i == QDEPTH) ? 0 : i + 1];
      else if (tgt_hit)
        cq_nxt[i] = result;
      else
        cq_nxt[i] = cq_cur[i];
    end
  end
endmodule

// File: rtl/fpsw_unit.sv
module fpsw_unit
  import fpsw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic              op_done,
  input  logic [4:0]        op_flags,
  input  logic              cmp_done,
  input  logic [1:0]        cmp_rel,
  input  logic [4:0]        cmp_mask,
  input  logic [3:0]        cmp_target,
  input  logic [4:0]        cmp_flags,
  output logic [31:0]       status,
  output logic [1:0]        round_mode,
  output logic              flush_en,
  output logic              trap_req
);
  logic [WORD_W-1:0] word_q, word_d;
  logic              trap_q;

  logic [NFLAG-1:0]  sticky_nxt;
  logic              trap_hit;
  logic              cb_nxt;
  logic [QDEPTH:0]   cq_nxt;
  logic              cmp_result;
  rnd_t              rnd;

  fpsw_flag_merge u_flags (
    .sticky_cur (word_q[STICKY_LO+NFLAG-1:STICKY_LO]),
    .enables    (word_q[ENA_LO+NFLAG-1:ENA_LO]),
    .op_v       (op_done),
    .op_f       (op_flags),
    .cmp_v      (cmp_done),
    .cmp_f      (cmp_flags),
    .sticky_nxt (sticky_nxt),
    .trap_hit   (trap_hit)
  );

  fpsw_cond_update u_cond (
    .cmp_v  (cmp_done),
    .rel    (cmp_rel),
    .mask   (cmp_mask),
    .target (cmp_target),
    .cb_cur (word_q[COND_BIT]),
    .cq_cur (word_q[CQ_HI:CQ_LO]),
    .cb_nxt (cb_nxt),
    .cq_nxt (cq_nxt),
    .result (cmp_result)
  );

  fpsw_decode u_dec (
    .word  (word_q),
    .rnd   (rnd),
    .flush (flush_en)
  );

  always_comb begin
    word_d = word_q;
    if (wr_en) begin
      word_d = wr_data;
    end else begin
      word_d[STICKY_LO+NFLAG-1:STICKY_LO] = sticky_nxt;
      word_d[COND_BIT]                    = cb_nxt;
      word_d[CQ_HI:CQ_LO]                 = cq_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      trap_q <= 1'b0;
    end else begin
      word_q <= word_d;
      trap_q <= trap_hit && !wr_en;
    end
  end

  always_comb begin
    status     = word_q;
    round_mode = rnd;
    trap_req   = trap_q;
  end
endmodule

// File: rtl/fpsw_chk.sv
module fpsw_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic        op_done,
  input logic        cmp_done,
  input logic [31:0] status,
  input logic        trap_req
);
  // R2
  a_r2_write_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> status == $past(wr_data));
  // R2 / R5
  a_r2_no_trap_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !trap_req);
  // R4
  a_r4_sticky_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((status[31:27] & $past(status[31:27])) == $past(status[31:27])));
  // R5
  a_r5_trap_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_done || cmp_done) |=> !trap_req);
  // R6
  a_r6_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !op_done && !cmp_done) |=> $stable(status));
  // R3 / R8: control and enable bits move only through writes
  a_r8_ctrl_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> status[10:0] == $past(status[10:0]));
endmodule

bind fpsw_unit fpsw_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .op_done  (op_done),
  .cmp_done (cmp_done),
  .status   (status),
  .trap_req (trap_req)
);

// File: tb/sim_fpsw_unit.sv
module sim_fpsw_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        op_done = 1'b0;
  logic [4:0]  op_flags = '0;
  logic        cmp_done = 1'b0;
  logic [1:0]  cmp_rel = '0;
  logic [4:0]  cmp_mask = '0;
  logic [3:0]  cmp_target = '0;
  logic [4:0]  cmp_flags = '0;
  logic [31:0] status;
  logic [1:0]  round_mode;
  logic        flush_en;
  logic        trap_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] exp_word = '0;
  logic        exp_trap = 1'b0;

  always #5 clk = ~clk;

  fpsw_unit u0 (.*);

  function automatic logic m_result(input logic [1:0] rel, input logic [4:0] mask);
    logic [4:0] sel;
    sel = 5'b10000 >> rel;
    return |(sel & mask);
  endfunction

  function automatic logic [31:0] m_next(
    input logic [31:0] old, input logic wr, input logic [31:0] wd,
    input logic opd, input logic [4:0] opf, input logic cd,
    input logic [1:0] rel, input logic [4:0] mask, input logic [3:0] tgt,
    input logic [4:0] cf);
    logic [31:0] r;
    logic [4:0]  fl;
    logic        c;
    if (wr) return wd;
    r  = old;
    fl = 5'd0;
    if (opd) fl = fl | opf;
    if (cd)  fl = fl | cf;
    for (int k = 0; k < 5; k++) if (fl[k]) r[27 + k] = 1'b1;
    if (cd) begin
      c = m_result(rel, mask);
      if (tgt == 0) begin
        for (int b = 11; b <= 20; b++) r[b] = old[b + 1];
        r[21] = old[26];
        r[26] = c;
      end else if (tgt <= 11) begin
        r[22 - tgt] = c;
      end
    end
    return r;
  endfunction

  function automatic logic m_trap(
    input logic [31:0] old, input logic wr, input logic opd, input logic [4:0] opf,
    input logic cd, input logic [4:0] cf);
    logic [4:0] fl;
    if (wr) return 1'b0;
    fl = (opd ? opf : 5'd0) | (cd ? cf : 5'd0);
    return (fl & old[4:0]) != 5'd0;
  endfunction

  task automatic check_all(input string tag);
    checks++;
    if (status !== exp_word) begin
      errors++;
      $display("FAIL %s status actual=%h expected=%h", tag, status, exp_word);
    end
    checks++;
    if (trap_req !== exp_trap) begin
      errors++;
      $display("FAIL %s trap_req actual=%b expected=%b", tag, trap_req, exp_trap);
    end
    checks++;
    if (round_mode !== exp_word[10:9] || flush_en !== exp_word[5]) begin
      errors++;
      $display("FAIL R3 (%s) decode actual=%0d/%b expected=%0d/%b",
               tag, round_mode, flush_en, exp_word[10:9], exp_word[5]);
    end
  endtask

  // Called just after a falling edge: drive, model, then check at the next falling edge
  task automatic step(input logic wr, input logic [31:0] wd, input logic opd,
                      input logic [4:0] opf, input logic cd, input logic [1:0] rel,
                      input logic [4:0] mask, input logic [3:0] tgt,
                      input logic [4:0] cf, input string tag);
    wr_en = wr; wr_data = wd; op_done = opd; op_flags = opf;
    cmp_done = cd; cmp_rel = rel; cmp_mask = mask; cmp_target = tgt; cmp_flags = cf;
    exp_trap = m_trap(exp_word, wr, opd, opf, cd, cf);
    exp_word = m_next(exp_word, wr, wd, opd, opf, cd, rel, mask, tgt, cf);
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after reset");

    step(1, 32'h0000_0600, 0, 0, 0, 0, 0, 0, 0, "R2 R3 toward -inf");
    step(1, 32'h0000_0220, 0, 0, 0, 0, 0, 0, 0, "R3 toward zero + flush");
    step(1, 32'h0000_0400, 0, 0, 0, 0, 0, 0, 0, "R3 toward +inf");
    step(1, 32'h0000_0004, 0, 0, 0, 0, 0, 0, 0, "R2 enable overflow");
    step(0, 0, 1, 5'b00001, 0, 0, 0, 0, 0, "R4 inexact sticky, no trap");
    step(0, 0, 1, 5'b00100, 0, 0, 0, 0, 0, "R5 overflow trap");
    step(0, 0, 1, 5'b00000, 0, 0, 0, 0, 0, "R6 zero flags unchanged");
    step(0, 0, 1, 5'b00010, 0, 0, 0, 0, 0, "R4 underflow keeps old flags");
    step(1, 32'h0000_001F, 1, 5'b11111, 1, 0, 5'b10000, 1, 5'b10000, "R2 write wins");
    step(0, 0, 0, 0, 1, 0, 5'b10000, 1, 0, "R7 R8 gt into bit 21");
    step(0, 0, 0, 0, 1, 1, 5'b01000, 11, 0, "R7 R8 lt into bit 11");
    step(0, 0, 0, 0, 1, 2, 5'b11011, 3, 0, "R7 R8 eq masked off");
    step(0, 0, 0, 0, 1, 3, 5'b00010, 0, 0, "R9 queue push");
    step(0, 0, 0, 0, 1, 2, 5'b00100, 0, 0, "R9 queue push again");
    step(0, 0, 0, 0, 1, 0, 5'b11111, 13, 0, "R11 out-of-range target");
    step(0, 0, 1, 5'b00001, 1, 3, 5'b00010, 0, 5'b10000, "R10 merged flags + trap");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R6 idle after trap");

    for (int n = 0; n < 3000; n++) begin
      logic        wr;
      logic [31:0] wd;
      wr = ($urandom % 8) == 0;
      wd = $urandom & 32'h07FF_FFFF;
      step(wr, wd, $urandom % 2, 5'($urandom), $urandom % 2, 2'($urandom),
           5'($urandom), 4'($urandom % 16), 5'($urandom % 4 == 0 ? $urandom : 0),
           "R4/R5/R7/R8/R9/R10/R11 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule